// File: doc/BRIEF.md
# Two-Processor Level Interrupt Cause/Mask Controller

The block gathers a set of level-sensitive interrupt source lines (32 by default) and presents them to two processors, called the primary and the secondary target. Each target owns its own cause register and its own enable (mask) register. Every cause register latches every source line. A target's interrupt output is raised when at least one source is latched in its cause register and also enabled in its mask register.

Software steers a source to one processor, to both, or to neither by setting bits in the two mask registers. It acknowledges a request by writing ones to the target's cause register. Because the sources are levels, a source whose line is still high latches again at once. A status port gives the primary target's lowest-numbered pending and enabled source, so the handler does not need to scan the word.

Register access uses a plain single-cycle bus with a 2-bit word index (byte offset divided by four). A write takes effect at the clock edge. Read data is combinational from the current register state.

Top module: `dual_irq_ctrl`

## Requirements
- R1: Reset clears both cause registers and both mask registers, drives both interrupt outputs low and drives the status valid flag low.
- R2: The word index selects a register. Index 0 is the primary cause, index 1 the primary mask, index 2 the secondary cause and index 3 the secondary mask. A read at an index returns that register, zero-extended to 32 bits.
- R3: A mask register is fully replaced by the written word on a write to its index. Mask bit 1 enables that source for that target.
- R4: On a write to a cause index, each data bit at 1 clears that cause bit, provided the source line is low in the same cycle. Data bits at 0 leave the cause bits as they are, and no write ever sets a cause bit.
- R5: A source line that is high at a clock edge sets its bit in both cause registers at that edge. The bit stays set after the line falls, until it is acknowledged.
- R6: When an acknowledge and a high source line meet on the same bit in the same cycle, the bit stays set. Acknowledging a line that is held high therefore never clears it.
- R7: Interrupt output t is high one cycle after the AND of target t's cause and mask is non-zero. It is low one cycle after that AND is zero.
- R8: A write to one target's cause or mask register leaves the other target's registers unchanged.
- R9: The status valid flag is high exactly when the primary cause AND primary mask is non-zero. The 5-bit index then gives the lowest-numbered set bit of that AND. The secondary target's registers have no effect on the status.
- R10: Writing all zeros to a target's mask and then all ones to its cause masks and clears every source for that target, with the source lines low. The output of that target falls in the cycle after the mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| bus_we_i | input | 1 | Write strobe for the register bus |
| bus_word_i | input | 2 | Register word index (byte offset / 4) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the indexed register |
| irq_o | output | 2 | Interrupt outputs: bit 0 is the primary target, bit 1 the secondary |
| pend_valid_o | output | 1 | At least one source is pending and enabled for the primary target |
| pend_idx_o | output | 5 | Lowest pending and enabled source for the primary target |

## Verification
The hardest case to reach from the ports is an acknowledge that lands on the same bit in the same cycle as a high source line. The bench sets up this collision on purpose: it drives a cause write and the source pattern in one cycle, so that the set-wins rule can be seen from the read-back value. The lowest-bit selection needs several pending sources at once. The bench therefore sweeps every single source and every ordered pair of sources through the primary path, and it computes the expected index from the isolated lowest bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BUS_W   = 32;
    localparam int N_TGT   = 2;
    localparam int WORD_W  = 2;

    // low bit of the word index picks the register kind
    typedef enum logic {
        KIND_CAUSE = 1'b0,
        KIND_MASK  = 1'b1
    } reg_kind_e;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] w1c_i,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    output logic [NUM_SRC-1:0] cause_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] cause;
        logic [NUM_SRC-1:0] mask;
        logic               irq;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // acknowledge first, then sources re-latch: set wins
        st_d.cause = (st_q.cause & ~w1c_i) | src_i;
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
        st_d.irq   = |(st_q.cause & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign irq_o   = st_q.irq;

    // R5
    src_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_i) |=> ((cause_o & $past(src_i)) == $past(src_i)));

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(w1c_i & ~src_i)) |=> ((cause_o & $past(w1c_i & ~src_i)) == '0));

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(src_i)) == '0));

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_o == $past(mask_wdata_i)));

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cause_o & mask_o)) |=> irq_o);

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_o & mask_o) == '0) |=> !irq_o);
endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        idx_o = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (pend_i[k]) begin
                idx_o = IDX_W'(k);
            end
        end
        valid_o = |pend_i;
    end

    // R9
    lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (pend_i[idx_o] &&
                     ((pend_i & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0)));
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                           bus_we_i,
    input  logic [WORD_W-1:0]              bus_word_i,
    input  logic [BUS_W-1:0]               bus_wdata_i,
    input  logic [N_TGT-1:0][NUM_SRC-1:0]  cause_i,
    input  logic [N_TGT-1:0][NUM_SRC-1:0]  mask_i,
    output logic [N_TGT-1:0][NUM_SRC-1:0]  w1c_o,
    output logic [N_TGT-1:0]               mask_we_o,
    output logic [NUM_SRC-1:0]             mask_wdata_o,
    output logic [BUS_W-1:0]               bus_rdata_o
);
    reg_kind_e kind;
    logic      tgt;

    assign kind         = reg_kind_e'(bus_word_i[0]);
    assign tgt          = bus_word_i[1];
    assign mask_wdata_o = bus_wdata_i[NUM_SRC-1:0];

    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        logic hit;
        assign hit          = bus_we_i && (tgt == 1'(t));
        assign w1c_o[t]     = (hit && kind == KIND_CAUSE) ? bus_wdata_i[NUM_SRC-1:0] : '0;
        assign mask_we_o[t] = hit && kind == KIND_MASK;
    end

    always_comb begin
        if (kind == KIND_MASK) begin
            bus_rdata_o = BUS_W'(mask_i[tgt]);
        end else begin
            bus_rdata_o = BUS_W'(cause_i[tgt]);
        end
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_we_i,
    input  logic [WORD_W-1:0]  bus_word_i,
    input  logic [BUS_W-1:0]   bus_wdata_i,
    output logic [BUS_W-1:0]   bus_rdata_o,
    output logic [N_TGT-1:0]   irq_o,
    output logic               pend_valid_o,
    output logic [IDX_W-1:0]   pend_idx_o
);
    logic [N_TGT-1:0][NUM_SRC-1:0] cause;
    logic [N_TGT-1:0][NUM_SRC-1:0] mask;
    logic [N_TGT-1:0][NUM_SRC-1:0] w1c;
    logic [N_TGT-1:0]              mask_we;
    logic [NUM_SRC-1:0]            mask_wdata;

    irqc_regif #(.NUM_SRC(NUM_SRC)) u_regif (
        .bus_we_i     (bus_we_i),
        .bus_word_i   (bus_word_i),
        .bus_wdata_i  (bus_wdata_i),
        .cause_i      (cause),
        .mask_i       (mask),
        .w1c_o        (w1c),
        .mask_we_o    (mask_we),
        .mask_wdata_o (mask_wdata),
        .bus_rdata_o  (bus_rdata_o)
    );

    for (genvar t = 0; t < N_TGT; t++) begin : g_bank
        irqc_bank #(.NUM_SRC(NUM_SRC)) u_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .src_i        (src_i),
            .w1c_i        (w1c[t]),
            .mask_we_i    (mask_we[t]),
            .mask_wdata_i (mask_wdata),
            .cause_o      (cause[t]),
            .mask_o       (mask[t]),
            .irq_o        (irq_o[t])
        );
    end

    irqc_lowest #(.NUM_SRC(NUM_SRC)) u_lowest (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (cause[0] & mask[0]),
        .valid_o (pend_valid_o),
        .idx_o   (pend_idx_o)
    );

    // R8
    primary_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_word_i[1]) |=> $stable(mask[0]));

    // R8
    secondary_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && !bus_word_i[1]) |=> $stable(mask[1]));
endmodule

// File: tb/test_dual_irq_ctrl.sv
`timescale 1ns/100ps
module test_dual_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        we = 1'b0;
    logic [1:0]  word = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;
    logic        pvalid;
    logic [4:0]  pidx;

    int compared = 0;
    int mismatched = 0;

    logic [31:0] m_cause [2];
    logic [31:0] m_mask  [2];
    logic [1:0]  m_irq;

    always #2 clk = ~clk;

    dual_irq_ctrl i_dual_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we_i(we),
        .bus_word_i(word), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .pend_valid_o(pvalid), .pend_idx_o(pidx)
    );

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] low_idx(logic [31:0] x);
        logic [31:0] iso;
        iso = x & (~x + 32'd1);
        return 5'($clog2(iso));
    endfunction

    // compare every observable against the model (called after a negedge)
    task automatic check_all(string req);
        logic [31:0] pend;
        pend = m_cause[0] & m_mask[0];
        cmp(req, "irq", 32'(irq), 32'(m_irq));
        cmp(req, "valid", 32'(pvalid), 32'(pend != 0));
        if (pend != 0) cmp(req, "index", 32'(pidx), 32'(low_idx(pend)));
        we = 1'b0;
        for (int w = 0; w < 4; w++) begin
            word = 2'(w);
            #0.2;
            cmp(req, $sformatf("read word %0d", w), rdata,
                w[0] ? m_mask[w >> 1] : m_cause[w >> 1]);
        end
    endtask

    // one clock cycle of stimulus, model update, then full comparison
    task automatic step(string req, logic [31:0] s, logic w, logic [1:0] wi, logic [31:0] wd);
        src = s; we = w; word = wi; wdata = wd;
        @(posedge clk);
        for (int t = 0; t < 2; t++) begin
            m_irq[t] = |(m_cause[t] & m_mask[t]);
        end
        for (int t = 0; t < 2; t++) begin
            logic [31:0] ack;
            ack = (w && wi == 2'(2 * t)) ? wd : 32'h0;
            m_cause[t] = (m_cause[t] & ~ack) | s;
            if (w && wi == 2'(2 * t + 1)) m_mask[t] = wd;
        end
        @(negedge clk);
        we = 1'b0;
        src = '0;
        check_all(req);
    endtask

    task automatic idle(string req, int n);
        for (int i = 0; i < n; i++) step(req, 32'h0, 1'b0, 2'd0, 32'h0);
    endtask

    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int t = 0; t < 2; t++) begin
            m_cause[t] = '0; m_mask[t] = '0;
        end
        m_irq = '0;
        #9;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1", 2);

        // R2 R3: mask write and read back at every index
        step("R3", 0, 1, 2'd1, 32'hA5A5_0F0F);
        step("R3", 0, 1, 2'd3, 32'h1234_5678);
        step("R2", 0, 1, 2'd1, 32'hFFFF_FFFF);
        step("R8", 0, 1, 2'd3, 32'h0000_0000);

        // R5 R9 R4 R7: every single source
        for (int k = 0; k < 32; k++) begin
            step("R5", 32'h1 << k, 0, 2'd0, 0);
            step("R7", 0, 0, 2'd0, 0);
            step("R4", 0, 1, 2'd0, 32'h0);        // zero write: no effect
            step("R4", 0, 1, 2'd0, 32'h1 << k);   // ack primary
            step("R8", 0, 1, 2'd2, 32'h1 << k);   // ack secondary
            step("R7", 0, 0, 2'd0, 0);
        end

        // R9: every pair of sources, lowest index wins
        for (int i = 0; i < 32; i++) begin
            for (int j = i + 1; j < 32; j++) begin
                step("R9", (32'h1 << i) | (32'h1 << j), 0, 2'd0, 0);
                step("R9", 0, 1, 2'd0, 32'hFFFF_FFFF);
                step("R8", 0, 1, 2'd2, 32'hFFFF_FFFF);
            end
        end

        // R6: ack collides with a high line on the same bit
        step("R6", 32'h0000_0100, 0, 2'd0, 0);
        step("R6", 32'h0000_0100, 1, 2'd0, 32'h0000_0100);
        step("R6", 32'h0000_0100, 1, 2'd0, 32'h0000_0100);
        step("R6", 0, 1, 2'd0, 32'h0000_0100);
        cmp("R6", "cleared after line fell", 32'(pvalid), 32'h0);

        // R9: secondary-only pending leaves status invalid
        step("R9", 0, 1, 2'd1, 32'h0);
        step("R9", 0, 1, 2'd3, 32'h0000_8000);
        step("R9", 32'h0000_8000, 0, 2'd0, 0);
        step("R9", 0, 0, 2'd0, 0);
        cmp("R9", "secondary-only valid", 32'(pvalid), 32'h0);
        cmp("R7", "secondary irq", 32'(irq), 32'h2);

        // R8: primary mask write leaves secondary alone
        step("R8", 0, 1, 2'd1, 32'hFFFF_0000);
        step("R8", 0, 1, 2'd0, 32'hFFFF_FFFF);

        // R10: quiesce both targets
        step("R10", 32'h00F0_000F, 1, 2'd1, 32'hFFFF_FFFF);
        step("R10", 0, 0, 2'd0, 0);
        step("R10", 0, 1, 2'd1, 32'h0);
        step("R10", 0, 1, 2'd0, 32'hFFFF_FFFF);
        step("R10", 0, 1, 2'd3, 32'h0);
        step("R10", 0, 1, 2'd2, 32'hFFFF_FFFF);
        idle("R10", 2);
        cmp("R10", "quiet irq", 32'(irq), 32'h0);

        // mixed patterns from an LFSR
        begin
            logic [31:0] lf = 32'hACE1_2468;
            for (int n = 0; n < 300; n++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                step("R5", lf & {32{lf[3]}} & 32'h0F0F_F0F0, lf[0], lf[5:4], {lf[15:0], lf[31:16]});
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule